// File: doc/BRIEF.md
# Two-Phase DRAM Address Pin Multiplexer with Strapped Select Pin

This block folds a flat system address onto the narrow address pin bus of a multiplexed-address DRAM. While the row strobe is being prepared, the pins carry the row part of the address. While the column strobe is being prepared, they carry the column part. A refresh engine can take over the pins at any time and present its own row counter. A separate timing generator supplies the phase and refresh selects and drives the strobes themselves.

The top pin needs special handling. The memory device decodes only thirteen of the fourteen address bits. During the row phase the top pin must sit at a fixed level that depends on the device variant, so it acts as a strap. During the column phase the same pin carries a real high-order address bit, so it cannot be tied to a rail. The strap level is a parameter. The highest system address bit selects which half of the address space the device serves. A registered flag reports any access whose half-select bit disagrees with the strap.

Every output is registered. A change of select or address reaches the pins on the next rising clock edge, so the pins are settled before the timing generator moves a strobe.

Top module: `addr_pin_mux`

## Requirements
- R1: While rst_n is low, pin_bus equals {STRAP_LEVEL, 6'b0} and half_mismatch is 0.
- R2: In the row phase (refresh=0, col_phase=0), pin_bus[5:0] equals sys_addr[5:0].
- R3: In the row phase, pin_bus[6] equals STRAP_LEVEL (1 drives high, 0 drives low), whatever the value of sys_addr.
- R4: In the column phase (refresh=0, col_phase=1), pin_bus[6:0] equals sys_addr[12:6], so the top pin carries address bit 12.
- R5: refresh=1 takes priority over col_phase. pin_bus[5:0] then equals refresh_row and pin_bus[6] equals STRAP_LEVEL, and sys_addr has no effect on the pins.
- R6: When refresh=0, in either phase, half_mismatch is 1 exactly when sys_addr[13] differs from STRAP_LEVEL.
- R7: When refresh=1, half_mismatch is 0 whatever sys_addr[13] is.
- R8: The outputs are registered. Inputs sampled at one rising edge appear at that edge, and an input change between edges leaves the outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_addr | input | 14 | System address; bit 13 is the half select |
| col_phase | input | 1 | 0 selects the row word, 1 selects the column word |
| refresh | input | 1 | Hands the pins to the refresh row counter |
| refresh_row | input | 6 | Row to refresh |
| pin_bus | output | 7 | DRAM address pins |
| half_mismatch | output | 1 | Access falls outside this device's half |

## Verification
A wrong select decode or a wrong bit slice shows on pin_bus one clock after the offending inputs. The reference model compares the pins on every clock, so such a fault is caught in the first cycle that uses the affected mode. A strap driven to the wrong level appears at once on the top pin in both the row phase and the refresh phase. A missing or doubled register stage shows as a one-cycle shift, which the mid-cycle check after each input change exposes.

// File: rtl/amux_pkg.sv
package amux_pkg;

    // Which word is presented on the pin bus.
    typedef enum logic [1:0] {
        SEL_ROW     = 2'd0,
        SEL_COL     = 2'd1,
        SEL_REFRESH = 2'd2
    } amux_sel_e;

    // Refresh wins over the phase select.
    function automatic amux_sel_e amux_pick(input logic refresh, input logic col_phase);
        if (refresh) begin
            return SEL_REFRESH;
        end
        if (col_phase) begin
            return SEL_COL;
        end
        return SEL_ROW;
    endfunction

endpackage

// File: rtl/amux_sel_decode.sv
module amux_sel_decode
    import amux_pkg::*;
(
    input  logic      refresh,
    input  logic      col_phase,
    output amux_sel_e sel
);
    always_comb begin
        sel = amux_pick(refresh, col_phase);
    end
endmodule

// File: rtl/amux_word_build.sv
module amux_word_build
    import amux_pkg::*;
#(
    parameter int   ROW_BITS    = 6,
    parameter int   COL_BITS    = 7,
    parameter logic STRAP_LEVEL = 1'b1,
    localparam int  ADDR_W      = ROW_BITS + COL_BITS + 1,
    localparam int  PIN_W       = COL_BITS
) (
    input  logic [ADDR_W-1:0]   sys_addr,
    input  amux_sel_e           sel,
    input  logic [ROW_BITS-1:0] refresh_row,
    output logic [PIN_W-1:0]    word_d,
    output logic                mismatch_d
);
    localparam int COL_LO = ROW_BITS;
    localparam int COL_HI = ROW_BITS + COL_BITS - 1;
    localparam int HALF_B = ADDR_W - 1;

    logic strap_bit;
    logic half_off;

    // The strap variant is fixed at elaboration.
    generate
        if (STRAP_LEVEL) begin : g_strap_high
            assign strap_bit = 1'b1;
            assign half_off  = ~sys_addr[HALF_B];
        end else begin : g_strap_low
            assign strap_bit = 1'b0;
            assign half_off  = sys_addr[HALF_B];
        end
    endgenerate

    always_comb begin
        word_d     = {strap_bit, sys_addr[ROW_BITS-1:0]};
        mismatch_d = half_off;
        unique case (sel)
            SEL_ROW: begin
                word_d     = {strap_bit, sys_addr[ROW_BITS-1:0]};
                mismatch_d = half_off;
            end
            SEL_COL: begin
                word_d     = sys_addr[COL_HI:COL_LO];
                mismatch_d = half_off;
            end
            SEL_REFRESH: begin
                word_d     = {strap_bit, refresh_row};
                mismatch_d = 1'b0;
            end
            default: begin
                word_d     = {strap_bit, sys_addr[ROW_BITS-1:0]};
                mismatch_d = half_off;
            end
        endcase
    end
endmodule

// File: rtl/amux_out_reg.sv
module amux_out_reg #(
    parameter int             PIN_W      = 7,
    parameter logic [PIN_W-1:0] RESET_WORD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] word_in,
    input  logic             mismatch_in,
    output logic [PIN_W-1:0] pins,
    output logic             mismatch
);
    typedef struct packed {
        logic [PIN_W-1:0] pins;
        logic             miss;
    } out_state_t;

    out_state_t st_d;
    out_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pins = word_in;
        st_d.miss = mismatch_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pins <= RESET_WORD;
            st_q.miss <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pins     = st_q.pins;
    assign mismatch = st_q.miss;
endmodule

// File: rtl/addr_pin_mux.sv
module addr_pin_mux
    import amux_pkg::*;
#(
    parameter int   ROW_BITS    = 6,
    parameter int   COL_BITS    = 7,
    parameter logic STRAP_LEVEL = 1'b1,
    localparam int  ADDR_W      = ROW_BITS + COL_BITS + 1,
    localparam int  PIN_W       = COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   sys_addr,
    input  logic                col_phase,
    input  logic                refresh,
    input  logic [ROW_BITS-1:0] refresh_row,
    output logic [PIN_W-1:0]    pin_bus,
    output logic                half_mismatch
);
    localparam logic [PIN_W-1:0] RESET_WORD = {STRAP_LEVEL, {ROW_BITS{1'b0}}};

    amux_sel_e        sel;
    logic [PIN_W-1:0] word_d;
    logic             mismatch_d;

    amux_sel_decode u_dec (
        .refresh   (refresh),
        .col_phase (col_phase),
        .sel       (sel)
    );

    amux_word_build #(
        .ROW_BITS    (ROW_BITS),
        .COL_BITS    (COL_BITS),
        .STRAP_LEVEL (STRAP_LEVEL)
    ) u_build (
        .sys_addr    (sys_addr),
        .sel         (sel),
        .refresh_row (refresh_row),
        .word_d      (word_d),
        .mismatch_d  (mismatch_d)
    );

    amux_out_reg #(
        .PIN_W      (PIN_W),
        .RESET_WORD (RESET_WORD)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_in     (word_d),
        .mismatch_in (mismatch_d),
        .pins        (pin_bus),
        .mismatch    (half_mismatch)
    );
endmodule

// File: rtl/amux_chk.sv
module amux_chk #(
    parameter int   ROW_BITS    = 6,
    parameter int   COL_BITS    = 7,
    parameter logic STRAP_LEVEL = 1'b1,
    localparam int  ADDR_W      = ROW_BITS + COL_BITS + 1,
    localparam int  PIN_W       = COL_BITS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   sys_addr,
    input logic                col_phase,
    input logic                refresh,
    input logic [ROW_BITS-1:0] refresh_row,
    input logic [PIN_W-1:0]    pin_bus,
    input logic                half_mismatch
);
    // Set once a full clock has passed out of reset, so $past is meaningful.
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2
    a_r2_row_low_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(refresh) && !$past(col_phase))
        |-> pin_bus[ROW_BITS-1:0] == $past(sys_addr[ROW_BITS-1:0]));

    // R3 and R5: the top pin holds the strap outside the column phase
    a_r3_strap_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(refresh) || !$past(col_phase)))
        |-> pin_bus[PIN_W-1] == STRAP_LEVEL);

    // R4
    a_r4_col_word: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(refresh) && $past(col_phase))
        |-> pin_bus == $past(sys_addr[ROW_BITS+COL_BITS-1:ROW_BITS]));

    // R5
    a_r5_refresh_row: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(refresh))
        |-> pin_bus[ROW_BITS-1:0] == $past(refresh_row));

    // R6
    a_r6_half_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(refresh))
        |-> half_mismatch == ($past(sys_addr[ADDR_W-1]) != STRAP_LEVEL));

    // R7
    a_r7_refresh_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(refresh)) |-> !half_mismatch);
endmodule

bind addr_pin_mux amux_chk #(
    .ROW_BITS    (ROW_BITS),
    .COL_BITS    (COL_BITS),
    .STRAP_LEVEL (STRAP_LEVEL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sys_addr      (sys_addr),
    .col_phase     (col_phase),
    .refresh       (refresh),
    .refresh_row   (refresh_row),
    .pin_bus       (pin_bus),
    .half_mismatch (half_mismatch)
);

// File: tb/tb_addr_pin_mux.sv
module tb_addr_pin_mux;
    localparam logic STRAP = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] sys_addr = '0;
    logic        col_phase = 1'b0;
    logic        refresh = 1'b0;
    logic [5:0]  refresh_row = '0;
    logic [6:0]  pin_bus;
    logic        half_mismatch;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0] exp_pins;
    logic       exp_miss;

    always #2.5 clk = ~clk;

    addr_pin_mux #(.STRAP_LEVEL(STRAP)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sys_addr      (sys_addr),
        .col_phase     (col_phase),
        .refresh       (refresh),
        .refresh_row   (refresh_row),
        .pin_bus       (pin_bus),
        .half_mismatch (half_mismatch)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare the registered outputs against the expectation for the last edge.
    task automatic compare(input logic was_reset, input logic was_ref, input logic was_col);
        if (was_reset) begin
            check("R1 pins", {1'b0, pin_bus}, {1'b0, exp_pins});
            check("R1 flag", {7'b0, half_mismatch}, {7'b0, exp_miss});
        end else if (was_ref) begin
            check("R5 pins", {1'b0, pin_bus}, {1'b0, exp_pins});
            check("R7 flag", {7'b0, half_mismatch}, {7'b0, exp_miss});
        end else if (was_col) begin
            check("R4 pins", {1'b0, pin_bus}, {1'b0, exp_pins});
            check("R6 flag", {7'b0, half_mismatch}, {7'b0, exp_miss});
        end else begin
            check("R2 low pins", {2'b0, pin_bus[5:0]}, {2'b0, exp_pins[5:0]});
            check("R3 strap pin", {7'b0, pin_bus[6]}, {7'b0, exp_pins[6]});
            check("R6 flag", {7'b0, half_mismatch}, {7'b0, exp_miss});
        end
    endtask

    logic last_rst = 1'b1, last_ref = 1'b0, last_col = 1'b0;

    // One clock: check the previous result, apply new inputs, verify the
    // outputs hold until the edge, then record the new expectation.
    task automatic step(input logic rn, input logic [13:0] a, input logic c,
                        input logic r, input logic [5:0] rr);
        @(negedge clk);
        compare(last_rst, last_ref, last_col);
        rst_n       = rn;
        sys_addr    = a;
        col_phase   = c;
        refresh     = r;
        refresh_row = rr;
        #1;
        if (rn && !last_rst) begin
            check("R8 hold pins", {1'b0, pin_bus}, {1'b0, exp_pins});
            check("R8 hold flag", {7'b0, half_mismatch}, {7'b0, exp_miss});
        end
        if (!rn) begin
            exp_pins = {STRAP, 6'b0};
            exp_miss = 1'b0;
        end else if (r) begin
            exp_pins = {STRAP, rr};
            exp_miss = 1'b0;
        end else if (c) begin
            exp_pins = a[12:6];
            exp_miss = (a[13] != STRAP);
        end else begin
            exp_pins = {STRAP, a[5:0]};
            exp_miss = (a[13] != STRAP);
        end
        last_rst = !rn;
        last_ref = r;
        last_col = c;
    endtask

    initial begin
        exp_pins = {STRAP, 6'b0};
        exp_miss = 1'b0;
        // R1: reset with busy inputs
        step(1'b0, 14'h3FFF, 1'b1, 1'b0, 6'h2A);
        step(1'b0, 14'h1234, 1'b0, 1'b1, 6'h15);
        step(1'b0, 14'h0000, 1'b0, 1'b0, 6'h00);
        // R2/R3: row phase, in-half address
        step(1'b1, 14'h2015, 1'b0, 1'b0, 6'h00);
        // R4: column phase, bit 12 set drives top pin
        step(1'b1, 14'h3FC0, 1'b1, 1'b0, 6'h00);
        step(1'b1, 14'h2FFF, 1'b1, 1'b0, 6'h3F);
        // R3: row phase with bit 12 set still shows strap
        step(1'b1, 14'h3000, 1'b0, 1'b0, 6'h00);
        // R6: out-of-half in both phases
        step(1'b1, 14'h003F, 1'b0, 1'b0, 6'h00);
        step(1'b1, 14'h0040, 1'b1, 1'b0, 6'h00);
        // R5/R7: refresh beats column phase, no flag for out-of-half
        step(1'b1, 14'h0FFF, 1'b1, 1'b1, 6'h2B);
        step(1'b1, 14'h0000, 1'b0, 1'b1, 6'h00);
        step(1'b1, 14'h3FFF, 1'b0, 1'b1, 6'h3F);
        // R8: alternating phase every clock
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 14'h2A55 ^ 14'(i * 14'h0111), 1'(i & 1), 1'b0, 6'(i));
        end
        // Mixed patterns
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(1'b1, rv[13:0], rv[14], (rv[17:15] == 3'd0), rv[23:18]);
        end
        // R1: reset mid-run, then recover
        step(1'b0, 14'h1FFF, 1'b1, 1'b0, 6'h11);
        step(1'b1, 14'h2001, 1'b0, 1'b0, 6'h00);
        step(1'b1, 14'h2001, 1'b0, 1'b0, 6'h00);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule